// File: doc/BRIEF.md
# Descriptor Ring Slot Walker

This block walks two descriptor rings held in system memory on behalf of an infrared frame controller. One ring describes receive buffers and the other transmit buffers. Both sit in one 1 KB-aligned window: receive slots start at the window base and transmit slots start 0x200 bytes above it. Each slot is 8 bytes. The first 32-bit word carries a length in bits 15:0 (only 11:0 meaningful), a spare byte in bits 23:16 and a control/status byte in bits 31:24. The second word carries the buffer address. Bit 7 of the control byte marks a slot as owned by hardware.

The walker reads a slot and checks the ownership bit. For an owned slot it offers the length, buffer address, control byte and ring identity to the frame datapath over a valid/ready handshake. It then waits for the datapath's completion pulse, writes the first word back with status and the ownership bit cleared, and advances that ring's index. The index wraps at the configured ring size. When the walker reads a slot that is not owned, it parks that ring. A parked ring stays idle until software writes a prompt; the walker does not poll. Software sees the indices and programs the base, size and prompt through a byte-wide register port. The interrupt logic receives one-cycle event pulses.

Top module: `ring_slot_walker`

## Requirements
- R1: After reset, both ring indices read 0, the base and size registers read 0, and both rings are parked. No memory request, slot offer or event is issued until a prompt is written.
- R2: Register addresses are 0 receive index, 1 transmit index, 2 base bits 17:10, 3 base bits 25:18, 4 base bits 31:26 and 5 ring size. Address 6 is the prompt. The index registers read as 6-bit values. Register 4 stores its low six bits and reads its top two bits as zero.
- R3: A slot's first word is at `{base[31:10], isTx, index[5:0], 3'b000}` and its second word is 4 bytes above. A request holds its address and direction until it is acknowledged.
- R4: Reading a slot whose control bit 7 is clear parks that ring on the same index without advancing it. Writing the prompt register with bit 0 set re-arms both rings. A prompt write with bit 0 clear has no effect.
- R5: For an owned slot, `slotValid` rises with `slotLen` = word0[11:0], `slotCtrl` = word0[31:24] and `slotBufAddr` = word1. These values hold until `slotReady` is seen.
- R6: Receive writeback: the control byte becomes `doneStatus & 0x7E`. The status bits are 6 decode error, 5 CRC error, 4 too long, 3 overflow, 2 bad framing and 1 end of frame. The length field becomes `doneCount` saturated at 4095, and the spare byte is preserved.
- R7: Transmit writeback: bit 7 is cleared, bits 6:1 of the fetched control byte are kept, and bit 0 is set to `doneStatus[0]` (underrun). The length and spare byte are unchanged.
- R8: After each writeback the index advances and wraps: the last index of a ring is `{nibble, 2'b11}`. The nibble is size bits 3:0 for receive and bits 7:4 for transmit, so 0x0/0x1/0x3/0x7/0xF give 4/8/16/32/64 slots. Writing the size register resets both indices to 0.
- R9: When both rings are armed, the receive ring is examined first.
- R10: Each receive completion pulses `evtRxDone` for one cycle. A transmit completion pulses `evtTxDone` only if its fetched control bit 2 was set. The two pulses never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| memReq | output | 1 | Descriptor memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Request acknowledge |
| slotValid | output | 1 | Slot offered to datapath |
| slotReady | input | 1 | Datapath accepts slot |
| slotIsTx | output | 1 | Offered slot is from the transmit ring |
| slotLen | output | 12 | Slot length |
| slotBufAddr | output | 32 | Slot buffer address |
| slotCtrl | output | 8 | Slot control byte |
| doneValid | input | 1 | Datapath finished the slot |
| doneStatus | input | 8 | Completion status bits |
| doneCount | input | 16 | Received byte count |
| evtRxDone | output | 1 | Receive slot completed pulse |
| evtTxDone | output | 1 | Transmit completion event pulse |

## Verification
The bench drives slots that carry a length that needs saturating and status bytes whose bit 7 and bit 0 must be dropped or taken. A design that leaked ownership or masked the wrong bits would write a word that fails the comparison. It checks the transmit ring wrapping at four slots, the size write clearing both indices, and a wrap that lands on an already-completed slot. A design with the wrong mask or with no reset on the size write would read back the wrong index or fetch from the wrong address. It also checks that a prompt with bit 0 clear causes no memory traffic, that an unowned slot parks its ring without moving the index, and that receive wins when both rings hold owned slots. A design that polled, advanced past an idle slot or served transmit first would be caught by the request count, the index read or `slotIsTx`.

// File: rtl/ringwalk_pkg.sv
package ringwalk_pkg;
  localparam int NIB_W = 4;
  localparam int IDX_W = NIB_W + 2;
  localparam int LEN_W = 12;
  localparam int CNT_W = 16;
  localparam int BASE_LO = 10;

  localparam logic [2:0] RA_RXIDX  = 3'd0;
  localparam logic [2:0] RA_TXIDX  = 3'd1;
  localparam logic [2:0] RA_BASE0  = 3'd2;
  localparam logic [2:0] RA_BASE1  = 3'd3;
  localparam logic [2:0] RA_BASE2  = 3'd4;
  localparam logic [2:0] RA_SIZE   = 3'd5;
  localparam logic [2:0] RA_PROMPT = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_OFFER, ST_WAIT, ST_WB
  } walkState_t;

  typedef struct packed {
    logic latchW0;
    logic latchW1;
    logic latchDone;
    logic advance;
    logic selTx;
    logic wordSel;
  } walkStrobe_t;
endpackage

// File: rtl/ringwalk_dp.sv
module ringwalk_dp
  import ringwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              promptPulse,
  input  walkStrobe_t       stb,
  input  logic [31:0]       memRdata,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWdata,
  input  logic [7:0]        doneStatus,
  input  logic [CNT_W-1:0]  doneCount,
  output logic [LEN_W-1:0]  slotLen,
  output logic [31:0]       slotBufAddr,
  output logic [7:0]        slotCtrl,
  output logic              ownBit,
  output logic              txEventReq
);
  logic [7:0]       baseLo, baseMid, sizeReg, doneStat;
  logic [5:0]       baseHi;
  logic [IDX_W-1:0] rxIdx, txIdx, rxMask, txMask, nextRx, nextTx, curIdx;
  logic [31:0]      word0, word1;
  logic [CNT_W-1:0] doneCnt;
  logic [LEN_W-1:0] satLen;
  logic             sizeWr;

  assign rxMask = {sizeReg[NIB_W-1:0], 2'b11};
  assign txMask = {sizeReg[2*NIB_W-1:NIB_W], 2'b11};
  assign nextRx = (rxIdx + IDX_W'(1)) & rxMask;
  assign nextTx = (txIdx + IDX_W'(1)) & txMask;
  assign curIdx = stb.selTx ? txIdx : rxIdx;
  assign sizeWr = regWrEn && (regAddr == RA_SIZE);
  assign promptPulse = regWrEn && (regAddr == RA_PROMPT) && regWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLo <= '0; baseMid <= '0; baseHi <= '0; sizeReg <= '0;
      rxIdx <= '0; txIdx <= '0; word0 <= '0; word1 <= '0;
      doneStat <= '0; doneCnt <= '0;
    end else begin
      if (stb.latchW0) word0 <= memRdata;
      if (stb.latchW1) word1 <= memRdata;
      if (stb.latchDone) begin
        doneStat <= doneStatus;
        doneCnt  <= doneCount;
      end
      if (regWrEn) begin
        case (regAddr)
          RA_BASE0: baseLo  <= regWrData;
          RA_BASE1: baseMid <= regWrData;
          RA_BASE2: baseHi  <= regWrData[5:0];
          RA_SIZE:  sizeReg <= regWrData;
          default: ;
        endcase
      end
      if (sizeWr) begin
        rxIdx <= '0;
        txIdx <= '0;
      end else if (stb.advance) begin
        if (stb.selTx) txIdx <= nextTx;
        else           rxIdx <= nextRx;
      end
    end
  end

  always_comb begin
    case (regAddr)
      RA_RXIDX: regRdData = {{(8-IDX_W){1'b0}}, rxIdx};
      RA_TXIDX: regRdData = {{(8-IDX_W){1'b0}}, txIdx};
      RA_BASE0: regRdData = baseLo;
      RA_BASE1: regRdData = baseMid;
      RA_BASE2: regRdData = {2'b00, baseHi};
      RA_SIZE:  regRdData = sizeReg;
      default:  regRdData = 8'h00;
    endcase
  end

  assign memAddr = {baseHi, baseMid, baseLo, stb.selTx, curIdx, stb.wordSel, 2'b00};
  assign satLen  = (|doneCnt[CNT_W-1:LEN_W]) ? {LEN_W{1'b1}} : doneCnt[LEN_W-1:0];
  assign memWdata = stb.selTx
    ? {1'b0, word0[30:25], doneStat[0], word0[23:0]}
    : {doneStat & 8'h7E, word0[23:16], {(16-LEN_W){1'b0}}, satLen};

  assign slotLen     = word0[LEN_W-1:0];
  assign slotCtrl    = word0[31:24];
  assign slotBufAddr = word1;
  assign ownBit      = memRdata[31];
  assign txEventReq  = word0[26];

  // R8: indices never leave the configured ring
  p_rx_in_ring_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxIdx & ~rxMask) == '0);
  p_tx_in_ring_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txIdx & ~txMask) == '0);
  p_size_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    sizeWr |=> (rxIdx == '0 && txIdx == '0));
endmodule

// File: rtl/ringwalk_ctrl.sv
module ringwalk_ctrl
  import ringwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        memAck,
  input  logic        ownBit,
  input  logic        txEventReq,
  input  logic        promptPulse,
  input  logic        slotReady,
  input  logic        doneValid,
  output walkStrobe_t stb,
  output logic        memReq,
  output logic        memWe,
  output logic        slotValid,
  output logic        evtRxDone,
  output logic        evtTxDone
);
  walkState_t state;
  logic curTx, rxArmed, txArmed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; curTx <= 1'b0;
      rxArmed <= 1'b0; txArmed <= 1'b0;
      evtRxDone <= 1'b0; evtTxDone <= 1'b0;
    end else begin
      evtRxDone <= 1'b0;
      evtTxDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rxArmed) begin
            curTx <= 1'b0; state <= ST_RD0;
          end else if (txArmed) begin
            curTx <= 1'b1; state <= ST_RD0;
          end
        end
        ST_RD0: if (memAck) begin
          if (ownBit) state <= ST_RD1;
          else begin
            if (curTx) txArmed <= 1'b0;
            else       rxArmed <= 1'b0;
            state <= ST_IDLE;
          end
        end
        ST_RD1:   if (memAck)    state <= ST_OFFER;
        ST_OFFER: if (slotReady) state <= ST_WAIT;
        ST_WAIT:  if (doneValid) state <= ST_WB;
        ST_WB: if (memAck) begin
          state     <= ST_IDLE;
          evtRxDone <= !curTx;
          evtTxDone <= curTx && txEventReq;
        end
        default: state <= ST_IDLE;
      endcase
      if (promptPulse) begin
        rxArmed <= 1'b1;
        txArmed <= 1'b1;
      end
    end
  end

  assign memReq    = (state == ST_RD0) || (state == ST_RD1) || (state == ST_WB);
  assign memWe     = (state == ST_WB);
  assign slotValid = (state == ST_OFFER);

  always_comb begin
    stb.latchW0   = (state == ST_RD0) && memAck;
    stb.latchW1   = (state == ST_RD1) && memAck;
    stb.latchDone = (state == ST_WAIT) && doneValid;
    stb.advance   = (state == ST_WB) && memAck;
    stb.selTx     = curTx;
    stb.wordSel   = (state == ST_RD1);
  end

  // R5: an offer is not withdrawn before it is accepted
  p_offer_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    slotValid && !slotReady |=> slotValid);
  // R4: with both rings parked, the walker stays off the memory port
  p_parked_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !rxArmed && !txArmed) |=> !memReq);
  // R10: event pulses are single-cycle and exclusive
  p_evt_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(evtRxDone && evtTxDone));
  p_evt_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    (evtRxDone || evtTxDone) |=> !(evtRxDone || evtTxDone));
endmodule

// File: rtl/ring_slot_walker.sv
module ring_slot_walker
  import ringwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic              slotValid,
  input  logic              slotReady,
  output logic              slotIsTx,
  output logic [LEN_W-1:0]  slotLen,
  output logic [31:0]       slotBufAddr,
  output logic [7:0]        slotCtrl,
  input  logic              doneValid,
  input  logic [7:0]        doneStatus,
  input  logic [CNT_W-1:0]  doneCount,
  output logic              evtRxDone,
  output logic              evtTxDone
);
  walkStrobe_t stb;
  logic ownBit, txEventReq, promptPulse;

  ringwalk_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .memAck(memAck), .ownBit(ownBit),
    .txEventReq(txEventReq), .promptPulse(promptPulse),
    .slotReady(slotReady), .doneValid(doneValid), .stb(stb),
    .memReq(memReq), .memWe(memWe), .slotValid(slotValid),
    .evtRxDone(evtRxDone), .evtTxDone(evtTxDone)
  );

  ringwalk_dp dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .promptPulse(promptPulse),
    .stb(stb), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .doneStatus(doneStatus), .doneCount(doneCount), .slotLen(slotLen),
    .slotBufAddr(slotBufAddr), .slotCtrl(slotCtrl), .ownBit(ownBit),
    .txEventReq(txEventReq)
  );

  assign slotIsTx = stb.selTx;

  // R3: a pending request keeps its address and direction until acknowledged
  p_req_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));
  // R6/R7: every writeback releases ownership and targets word 0
  p_wb_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !memWdata[31] && memAddr[2:0] == 3'b000);
endmodule

// File: tb/ring_slot_walker_tb.sv
module ring_slot_walker_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic        memReq, memWe, memAck;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        slotValid, slotIsTx;
  logic        slotReady = 1'b0;
  logic [11:0] slotLen;
  logic [31:0] slotBufAddr;
  logic [7:0]  slotCtrl;
  logic        doneValid = 1'b0;
  logic [7:0]  doneStatus = 8'h00;
  logic [15:0] doneCount = 16'h0000;
  logic        evtRxDone, evtTxDone;

  ring_slot_walker dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .slotValid(slotValid),
    .slotReady(slotReady), .slotIsTx(slotIsTx), .slotLen(slotLen),
    .slotBufAddr(slotBufAddr), .slotCtrl(slotCtrl), .doneValid(doneValid),
    .doneStatus(doneStatus), .doneCount(doneCount),
    .evtRxDone(evtRxDone), .evtTxDone(evtTxDone)
  );

  // expected base: hi=0x05 mid=0x4B lo=0xB3
  localparam logic [21:0] EXP_BASE = {6'h05, 8'h4B, 8'hB3};

  logic [31:0] mem [0:255];
  logic        pokeEn = 1'b0;
  logic [7:0]  pokeIdx = 8'h00;
  logic [31:0] pokeData = 32'h0;
  int addrErr = 0, reqCnt = 0, rxEvtCnt = 0, txEvtCnt = 0, cyc = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'h0;
      memAck <= 1'b0;
      memRdata <= 32'h0;
    end else if (pokeEn) begin
      mem[pokeIdx] <= pokeData;
      memAck <= 1'b0;
    end else if (memReq && !memAck) begin
      if (memAddr[31:10] != EXP_BASE) addrErr <= addrErr + 1;
      if (memWe) mem[memAddr[9:2]] <= memWdata;
      memRdata <= mem[memAddr[9:2]];
      memAck <= 1'b1;
    end else begin
      memAck <= 1'b0;
    end
    if (memReq) reqCnt <= reqCnt + 1;
    if (evtRxDone) rxEvtCnt <= rxEvtCnt + 1;
    if (evtTxDone) txEvtCnt <= txEvtCnt + 1;
  end

  int checks = 0, failures = 0;
  logic [5:0] rxIdx = 6'd0, txIdx = 6'd0;
  logic [7:0] sizeVal = 8'h00;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic poke(input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk);
    pokeEn = 1'b1; pokeIdx = idx; pokeData = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  function automatic logic [7:0] wIdx(input logic isTx, input logic [5:0] idx);
    return {isTx, idx, 1'b0};
  endfunction

  function automatic logic [5:0] nextIdx(input logic [5:0] idx, input logic [3:0] nib);
    return (idx + 6'd1) & {nib, 2'b11};
  endfunction

  function automatic logic [31:0] expWb(input logic isTx, input logic [7:0] ctrl,
      input logic [15:0] len, input logic [7:0] stat, input logic [15:0] cnt);
    if (isTx) return {1'b0, ctrl[6:1], stat[0], 8'h5A, len};
    return {stat & 8'h7E, 8'h5A, 4'h0, (cnt > 16'd4095) ? 12'hFFF : cnt[11:0]};
  endfunction

  task automatic arm(input logic isTx, input logic [7:0] ctrl, input logic [15:0] len,
      input logic [31:0] bufA);
    logic [5:0] idx;
    idx = isTx ? txIdx : rxIdx;
    poke(wIdx(isTx, idx), {ctrl, 8'h5A, len});
    poke(wIdx(isTx, idx) + 8'd1, bufA);
  endtask

  task automatic handle(input logic isTx, input logic [7:0] ctrl, input logic [15:0] len,
      input logic [31:0] bufA, input logic [7:0] stat, input logic [15:0] cnt);
    int n;
    int rx0, tx0;
    logic [5:0] idx;
    logic [7:0] rd;
    n = 0;
    rx0 = rxEvtCnt; tx0 = txEvtCnt;
    idx = isTx ? txIdx : rxIdx;
    while (!slotValid && n < 80) begin @(negedge clk); n++; end
    chk("R5 slot offered", {31'd0, slotValid}, 32'd1);
    chk("R9 ring of offered slot", {31'd0, slotIsTx}, {31'd0, isTx});
    chk("R5 slotCtrl", {24'd0, slotCtrl}, {24'd0, ctrl});
    chk("R5 slotLen", {20'd0, slotLen}, {20'd0, len[11:0]});
    chk("R5 slotBufAddr", slotBufAddr, bufA);
    @(negedge clk); @(negedge clk);
    chk("R5 offer held", {23'd0, slotValid, slotCtrl}, {23'd0, 1'b1, ctrl});
    slotReady = 1'b1;
    @(negedge clk);
    slotReady = 1'b0;
    doneStatus = stat; doneCount = cnt; doneValid = 1'b1;
    @(negedge clk);
    doneValid = 1'b0;
    repeat (30) @(negedge clk);
    chk(isTx ? "R7 tx writeback" : "R6 rx writeback", mem[wIdx(isTx, idx)],
        expWb(isTx, ctrl, len, stat, cnt));
    if (isTx) begin
      txIdx = nextIdx(txIdx, sizeVal[7:4]);
      regRead(3'd1, rd);
      chk("R8 tx index advance", {24'd0, rd}, {26'd0, txIdx});
      chk("R10 tx event count", txEvtCnt, tx0 + (ctrl[2] ? 1 : 0));
      chk("R10 no rx event on tx", rxEvtCnt, rx0);
    end else begin
      rxIdx = nextIdx(rxIdx, sizeVal[3:0]);
      regRead(3'd0, rd);
      chk("R8 rx index advance", {24'd0, rd}, {26'd0, rxIdx});
      chk("R10 rx event count", rxEvtCnt, rx0 + 1);
      chk("R10 no tx event on rx", txEvtCnt, tx0);
    end
  endtask

  task automatic serve(input logic isTx, input logic [7:0] ctrl, input logic [15:0] len,
      input logic [31:0] bufA, input logic [7:0] stat, input logic [15:0] cnt);
    arm(isTx, ctrl, len, bufA);
    regWrite(3'd6, 8'h01);
    handle(isTx, ctrl, len, bufA, stat, cnt);
  endtask

  // vector: {isTx, ctrl, len, buf, stat, cnt}
  localparam int NV = 12;
  localparam logic [80:0] VECS [0:NV-1] = '{
    {1'b0, 8'h80, 16'h0040, 32'h1000_0000, 8'h42, 16'd64},
    {1'b1, 8'h84, 16'h0100, 32'h2000_0000, 8'h00, 16'd0},
    {1'b1, 8'hC0, 16'h0FFF, 32'h2000_1000, 8'h01, 16'd0},
    {1'b0, 8'h80, 16'h0800, 32'h1000_2000, 8'hFF, 16'd5000},
    {1'b0, 8'h80, 16'h0800, 32'h1000_3000, 8'h02, 16'd4095},
    {1'b1, 8'hBC, 16'h0000, 32'h2000_2000, 8'hFE, 16'd0},
    {1'b1, 8'h85, 16'h0033, 32'h2000_3000, 8'h01, 16'd0},
    {1'b1, 8'h88, 16'hF123, 32'h2000_4000, 8'h00, 16'd0},
    {1'b0, 8'h80, 16'h0010, 32'h1000_4000, 8'h80, 16'd4096},
    {1'b0, 8'h80, 16'h0010, 32'h1000_5000, 8'h24, 16'd0},
    {1'b1, 8'hA4, 16'h0200, 32'h2000_5000, 8'h00, 16'd0},
    {1'b0, 8'h81, 16'h0010, 32'h1000_6000, 8'h10, 16'd1}
  };

  initial begin
    logic [7:0] rd;
    int r0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(3'd0, rd); chk("R1 rx index after reset", {24'd0, rd}, 32'd0);
    regRead(3'd1, rd); chk("R1 tx index after reset", {24'd0, rd}, 32'd0);
    regRead(3'd5, rd); chk("R1 size after reset", {24'd0, rd}, 32'd0);
    chk("R1 idle outputs", {29'd0, memReq, slotValid, evtRxDone | evtTxDone}, 32'd0);

    // R2 register map
    regWrite(3'd2, 8'hB3);
    regWrite(3'd3, 8'h4B);
    regWrite(3'd4, 8'hFF);
    regRead(3'd4, rd); chk("R2 base hi top bits zero", {24'd0, rd}, 32'h3F);
    regWrite(3'd4, 8'h05);
    regRead(3'd2, rd); chk("R2 base lo", {24'd0, rd}, 32'hB3);
    regRead(3'd3, rd); chk("R2 base mid", {24'd0, rd}, 32'h4B);
    regRead(3'd4, rd); chk("R2 base hi", {24'd0, rd}, 32'h05);
    sizeVal = 8'h01;
    regWrite(3'd5, sizeVal);

    // R1/R4: parked until a real prompt
    arm(1'b0, 8'h80, 16'h0123, 32'hCAFE_0000);
    r0 = reqCnt;
    regWrite(3'd6, 8'hFE);
    repeat (30) @(negedge clk);
    chk("R4 prompt bit0 clear ignored", reqCnt, r0);
    chk("R1 no offer before prompt", {31'd0, slotValid}, 32'd0);
    regWrite(3'd6, 8'h01);
    handle(1'b0, 8'h80, 16'h0123, 32'hCAFE_0000, 8'h02, 16'd300);

    // main table: rx size 8, tx size 4 (tx wraps)
    for (int v = 0; v < NV; v++) begin
      serve(VECS[v][80], VECS[v][79:72], VECS[v][71:56], VECS[v][55:24],
            VECS[v][23:16], VECS[v][15:0]);
    end

    // R4 unowned slot parks without advancing
    poke(wIdx(1'b0, rxIdx), 32'h0000_0000);
    poke(wIdx(1'b0, nextIdx(rxIdx, sizeVal[3:0])), {8'h80, 8'h5A, 16'h0010});
    regWrite(3'd6, 8'h01);
    repeat (30) @(negedge clk);
    chk("R4 unowned slot not offered", {31'd0, slotValid}, 32'd0);
    regRead(3'd0, rd); chk("R4 rx index parked", {24'd0, rd}, {26'd0, rxIdx});
    poke(wIdx(1'b0, nextIdx(rxIdx, sizeVal[3:0])), 32'h0);

    // R9 receive first when both rings are armed
    arm(1'b0, 8'h80, 16'h0044, 32'h3000_0000);
    arm(1'b1, 8'h84, 16'h0055, 32'h4000_0000);
    regWrite(3'd6, 8'h01);
    handle(1'b0, 8'h80, 16'h0044, 32'h3000_0000, 8'h08, 16'd68);
    handle(1'b1, 8'h84, 16'h0055, 32'h4000_0000, 8'h01, 16'd0);

    // R8 size write clears indices, rx wraps at 4
    sizeVal = 8'h00;
    regWrite(3'd5, sizeVal);
    rxIdx = 6'd0; txIdx = 6'd0;
    regRead(3'd0, rd); chk("R8 size write clears rx index", {24'd0, rd}, 32'd0);
    regRead(3'd1, rd); chk("R8 size write clears tx index", {24'd0, rd}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      serve(1'b0, 8'h80, 16'h0020, 32'h5000_0000 + k, 8'h02, 16'd32 + k);
    end
    regRead(3'd0, rd); chk("R8 rx wrap to 0 at 4 slots", {24'd0, rd}, 32'd0);

    chk("R3 accesses inside programmed base window", addrErr, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule